// File: doc/BRIEF.md
# Programmable-Length Serial CRC Engine

This block computes a cyclic redundancy check over a stream of data words. The polynomial and its length are both chosen at run time. The CRC register is between 1 and 16 bits long. The length field selects which stage produces the feedback bit. A tap field chooses which of the inner stages receive that feedback bit by XOR. The lowest term of the polynomial is always present, and so is the top term at the selected length. Neither is stored.

Software programs the taps, the length and a seed over a small register bus. It then writes data words into an eight-entry input queue and sets a start bit. The engine takes one word at a time from the queue and shifts it through the CRC register, one bit per clock and MSB first. Once the queue is empty and the last bit has been shifted, the engine drops its busy flag and pulses an interrupt for one cycle. Software can keep pushing words while the engine runs. Configuration and seed writes are locked out while the engine is busy.

Top module: `pcrc_top`

## Requirements
- R1: After a synchronous reset, the outputs read as follows: the CRC register is 0, busy is 0, irq is 0, fifo_empty is 1, fifo_full is 0 and overflow is 0. The length field is CRC_W-1 and the taps are 0.
- R2: Each shifted bit d updates the register as follows. The feedback bit is fb = d XOR stage[L], where L is the length field. Stage 0 loads fb. For 1 <= n <= L, stage n loads stage[n-1] XOR (tap[n] AND fb).
- R3: The engine runs only after a start command. For each word, it spends one cycle taking the word from the queue. It then spends DATA_W cycles shifting the word, MSB first, one bit per clock.
- R4: Stages above the length field always read as 0. This holds after seed writes, after length changes and after shifting.
- R5: The queue holds 8 words. fifo_full and fifo_empty report its state. A push while the queue is full is dropped and sets a sticky overflow flag. Writing 1 to control bit 1 clears that flag.
- R6: When the queue is empty and no word is in progress, a busy engine clears busy and raises irq for exactly one cycle. A start with an empty queue therefore finishes one cycle after it begins.
- R7: While busy is 1, the following are all ignored: writes to the CRC seed, writes to the taps, writes to the length field and further start commands.
- R8: bus_rdata shows the register addressed by bus_raddr one cycle later. The register map is as follows:
  - Address 0 is control and status. On write: bit 0 is start, bit 1 clears overflow and bits 11:8 are the length. On read: bit 0 is busy, bit 2 is empty, bit 3 is full, bit 4 is overflow and bits 11:8 are the length.
  - Address 1 holds the taps in bits 15:1. Bit 0 reads as 0.
  - Address 2 is the CRC register.
  - Address 3 is a write-only data push, using bits DATA_W-1:0.
- R9: Use length 15, taps 0x1020 and seed 0xFFFF, then feed the eight-bit words of the ASCII string "123456789". The result is 0x29B1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write address |
| bus_wdata | input | 16 | Write data |
| bus_raddr | input | 2 | Read address |
| bus_rdata | output | 16 | Registered read data |
| crc_value | output | CRC_W | Current CRC register |
| busy | output | 1 | Engine is processing |
| fifo_full | output | 1 | Input queue full |
| fifo_empty | output | 1 | Input queue empty |
| overflow | output | 1 | Sticky dropped-push flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The engine is tried against a standard 16-bit check string. This separates a correct feedback point and tap placement from one that is shifted by a stage or taken LSB first. A 5-bit polynomial with an all-ones seed shows whether the upper stages stay cleared. A 1-bit length reduces the CRC to running parity, which isolates the feedback path from the taps. Randomised runs push more words during processing and cover random lengths, taps and seeds. These runs make the per-cycle model catch errors in load and shift timing, in queue ordering and in the lockout of writes while busy.

// File: rtl/pcrc_pkg.sv
package pcrc_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_TAPS = 2'd1,
    A_CRC  = 2'd2,
    A_DATA = 2'd3
  } addr_e;

  localparam int CTRL_START = 0;
  localparam int CTRL_CLR   = 1;
  localparam int ST_BUSY    = 0;
  localparam int ST_EMPTY   = 2;
  localparam int ST_FULL    = 3;
  localparam int ST_OVF     = 4;
  localparam int LEN_LSB    = 8;
endpackage

// File: rtl/pcrc_step.sv
module pcrc_step #(
  parameter int CRC_W = 16,
  parameter int LEN_W = 4
) (
  input  logic [CRC_W-1:0] cur,
  input  logic [CRC_W-1:1] taps,
  input  logic [LEN_W-1:0] len,
  input  logic             din,
  output logic [CRC_W-1:0] nxt
);
  logic fb;
  assign fb     = din ^ cur[len];
  assign nxt[0] = fb;

  for (genvar n = 1; n < CRC_W; n++) begin : g_stage
    assign nxt[n] = (LEN_W'(n) <= len) ? (cur[n-1] ^ (taps[n] & fb)) : 1'b0;
  end
endmodule

// File: rtl/pcrc_fifo.sv
module pcrc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty,
  input  logic         clr_ovf,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         do_push, do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      ovf <= 1'b0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      if (push && full)  ovf <= 1'b1;
      else if (clr_ovf)  ovf <= 1'b0;
    end
  end

  a_r5_full_xor_empty: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_ovf) |=> ovf);
  a_r5_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> $stable(wp) && ovf);
endmodule

// File: rtl/pcrc_seq.sv
module pcrc_seq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_word,
  output logic              pop,
  output logic              shift_en,
  output logic              shift_bit,
  output logic              busy,
  output logic              irq
);
  localparam int CW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] word_q;
  logic [CW-1:0]     cnt_q;
  logic              have_q;

  assign pop       = busy && !have_q && !fifo_empty;
  assign shift_en  = busy && have_q;
  assign shift_bit = word_q[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      have_q <= 1'b0;
      irq    <= 1'b0;
      cnt_q  <= '0;
      word_q <= '0;
    end else begin
      irq <= 1'b0;
      if (!busy) begin
        if (start) busy <= 1'b1;
      end else if (have_q) begin
        word_q <= word_q << 1;
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) have_q <= 1'b0;
      end else if (!fifo_empty) begin
        word_q <= fifo_word;
        cnt_q  <= CW'(DATA_W);
        have_q <= 1'b1;
      end else begin
        busy <= 1'b0;
        irq  <= 1'b1;
      end
    end
  end

  a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  a_r6_irq_idle: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy);
  a_r3_shift_needs_busy: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> busy);
  a_r3_pop_then_shift: assert property (@(posedge clk) disable iff (rst)
    pop |=> shift_en);
  a_r6_done_from_empty: assert property (@(posedge clk) disable iff (rst)
    (busy && !shift_en && fifo_empty) |=> irq);
endmodule

// File: rtl/pcrc_top.sv
module pcrc_top import pcrc_pkg::*; #(
  parameter int CRC_W      = 16,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic [1:0]       bus_raddr,
  output logic [REG_W-1:0] bus_rdata,
  output logic [CRC_W-1:0] crc_value,
  output logic             busy,
  output logic             fifo_full,
  output logic             fifo_empty,
  output logic             overflow,
  output logic             irq
);
  localparam int LEN_W = $clog2(CRC_W);

  logic [CRC_W-1:0] crc_q, step_out, len_mask, wr_mask;
  logic [CRC_W-1:1] taps_q;
  logic [LEN_W-1:0] len_q, len_wr;
  logic [REG_W-1:0] status_w;
  logic [DATA_W-1:0] fifo_word;
  logic wr_ctrl, wr_taps, wr_crc, wr_data, start, clr_ovf;
  logic pop, shift_en, shift_bit;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign wr_taps = bus_we && (bus_addr == A_TAPS);
  assign wr_crc  = bus_we && (bus_addr == A_CRC);
  assign wr_data = bus_we && (bus_addr == A_DATA);
  assign start   = wr_ctrl && bus_wdata[CTRL_START];
  assign clr_ovf = wr_ctrl && bus_wdata[CTRL_CLR];
  assign len_wr  = bus_wdata[LEN_LSB +: LEN_W];

  always_comb begin
    for (int i = 0; i < CRC_W; i++) begin
      len_mask[i] = (LEN_W'(i) <= len_q);
      wr_mask[i]  = (LEN_W'(i) <= len_wr);
    end
  end

  pcrc_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(wr_data), .wdata(bus_wdata[DATA_W-1:0]),
    .pop(pop), .rdata(fifo_word), .full(fifo_full), .empty(fifo_empty),
    .clr_ovf(clr_ovf), .ovf(overflow)
  );

  pcrc_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .fifo_empty(fifo_empty),
    .fifo_word(fifo_word), .pop(pop), .shift_en(shift_en),
    .shift_bit(shift_bit), .busy(busy), .irq(irq)
  );

  pcrc_step #(.CRC_W(CRC_W), .LEN_W(LEN_W)) u_step (
    .cur(crc_q), .taps(taps_q), .len(len_q), .din(shift_bit), .nxt(step_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q  <= '0;
      taps_q <= '0;
      len_q  <= LEN_W'(CRC_W - 1);
    end else if (shift_en) begin
      crc_q <= step_out;
    end else if (!busy) begin
      if (wr_crc) crc_q <= bus_wdata[CRC_W-1:0] & len_mask;
      if (wr_taps) taps_q <= bus_wdata[CRC_W-1:1];
      if (wr_ctrl) begin
        len_q <= len_wr;
        crc_q <= crc_q & wr_mask;
      end
    end
  end

  assign crc_value = crc_q;

  always_comb begin
    status_w = '0;
    status_w[ST_BUSY]  = busy;
    status_w[ST_EMPTY] = fifo_empty;
    status_w[ST_FULL]  = fifo_full;
    status_w[ST_OVF]   = overflow;
    status_w[LEN_LSB +: LEN_W] = len_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_raddr)
        A_CTRL:  bus_rdata <= status_w;
        A_TAPS:  bus_rdata <= REG_W'({taps_q, 1'b0});
        A_CRC:   bus_rdata <= REG_W'(crc_q);
        default: bus_rdata <= '0;
      endcase
    end
  end

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (crc_q & ~len_mask) == '0);
  a_r7_crc_locked: assert property (@(posedge clk) disable iff (rst)
    (busy && !shift_en) |=> $stable(crc_q));
  a_r7_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(len_q) && $stable(taps_q)));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !bus_we) |=> $stable(crc_q));
endmodule

// File: tb/pcrc_top_test.sv
module pcrc_top_test;
  localparam int CRC_W = 16, DATA_W = 8, DEPTH = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, we = 1'b0;
  logic [1:0] addr = '0, raddr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [CRC_W-1:0] crc_value;
  logic busy, full, empty, ovf, irq;

  pcrc_top #(.CRC_W(CRC_W), .DATA_W(DATA_W), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_raddr(raddr), .bus_rdata(rdata), .crc_value(crc_value), .busy(busy),
    .fifo_full(full), .fifo_empty(empty), .overflow(ovf), .irq(irq)
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int q[$];
  bit m_busy = 0, m_have = 0, m_irq = 0, m_ovf = 0;
  int m_word = 0, m_cnt = 0, m_crc = 0, m_len = CRC_W - 1, m_taps = 0;

  function automatic int mask_of(int l);
    return (2 << l) - 1;
  endfunction

  function automatic int crc_bit(int c, int d, int l, int t);
    int poly = ((t << 1) | 1) & mask_of(l);
    int top  = (c >> l) & 1;
    c = (c << 1) & mask_of(l);
    if ((top ^ d) != 0) c = c ^ poly;
    return c;
  endfunction

  always @(posedge clk) begin
    bit full0, was_busy;
    if (rst) begin
      q.delete();
      m_busy = 0; m_have = 0; m_irq = 0; m_ovf = 0;
      m_word = 0; m_cnt = 0; m_crc = 0; m_len = CRC_W - 1; m_taps = 0;
    end else begin
      full0 = (q.size() == DEPTH);
      was_busy = m_busy;
      m_irq = 0;
      if (!m_busy) begin
        if (we && addr == 2'd0 && wdata[0]) m_busy = 1;
      end else if (m_have) begin
        m_crc = crc_bit(m_crc, (m_word >> (DATA_W - 1)) & 1, m_len, m_taps);
        m_word = (m_word << 1) & ((1 << DATA_W) - 1);
        m_cnt--;
        if (m_cnt == 0) m_have = 0;
      end else if (q.size() > 0) begin
        m_word = q.pop_front();
        m_cnt = DATA_W;
        m_have = 1;
      end else begin
        m_busy = 0;
        m_irq = 1;
      end
      if (we && !was_busy) begin
        if (addr == 2'd0) begin
          m_len = (wdata >> 8) & 15;
          m_crc = m_crc & mask_of(m_len);
        end
        if (addr == 2'd1) m_taps = (wdata >> 1) & 16'h7fff;
        if (addr == 2'd2) m_crc = wdata & mask_of(m_len);
      end
      if (we && addr == 2'd0 && wdata[1]) m_ovf = 0;
      if (we && addr == 2'd3) begin
        if (full0) m_ovf = 1;
        else q.push_back(wdata & ((1 << DATA_W) - 1));
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 crc register", crc_value, m_crc);
      check("R3 busy", busy, m_busy);
      check("R6 irq", irq, m_irq);
      check("R5 fifo_full", full, q.size() == DEPTH);
      check("R5 fifo_empty", empty, q.size() == 0);
      check("R5 overflow", ovf, m_ovf);
    end
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, int exp, string tag);
    @(negedge clk);
    raddr = a;
    @(negedge clk);
    check(tag, rdata, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    string s;
    int ones, seed;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 crc after reset", crc_value, 0);
    check("R1 busy after reset", busy, 0);
    check("R1 empty after reset", empty, 1);
    check("R1 irq after reset", irq, 0);
    rd(2'd0, 16'h0F04, "R1 R8 status after reset");
    rd(2'd1, 0, "R1 R8 taps after reset");

    s = "123456789";
    wr(2'd1, 16'h1020);
    wr(2'd0, 16'h0F00);
    wr(2'd2, 16'hFFFF);
    for (int i = 0; i < 8; i++) wr(2'd3, 16'(s[i]));
    check("R5 full after eight pushes", full, 1);
    wr(2'd0, 16'h0F01);
    repeat (3) @(negedge clk);
    wr(2'd3, 16'(s[8]));
    wait_idle();
    @(negedge clk);
    check("R9 check string result", crc_value, 16'h29B1);
    rd(2'd2, 16'h29B1, "R8 R9 crc readback");
    rd(2'd1, 16'h1020, "R8 taps readback");

    wr(2'd0, 16'h0400);
    check("R4 length change masks", crc_value, 16'h29B1 & 16'h1F);
    wr(2'd2, 16'hFFFF);
    check("R4 seed masked", crc_value, 16'h1F);
    wr(2'd1, 16'h0014);
    for (int i = 0; i < 5; i++) wr(2'd3, 16'(8'hA5 ^ (i * 37)));
    wr(2'd0, 16'h0401);
    wait_idle();
    @(negedge clk);
    check("R4 upper stages zero", crc_value >> 5, 0);

    for (int i = 0; i < 9; i++) wr(2'd3, 16'(i * 29));
    check("R5 overflow set", ovf, 1);
    rd(2'd0, 16'h0418, "R5 R8 status full and overflow");
    wr(2'd0, 16'h0402);
    check("R5 overflow cleared", ovf, 0);
    wr(2'd0, 16'h0401);
    wr(2'd2, 16'h1234);
    wr(2'd1, 16'hFFFE);
    wr(2'd0, 16'h0F01);
    rd(2'd1, 16'h0014, "R7 taps unchanged while busy");
    rd(2'd0, 16'h0400 | 16'h1, "R7 length unchanged while busy");
    wait_idle();

    wr(2'd0, 16'h0401);
    check("R6 busy on empty start", busy, 1);
    @(negedge clk);
    check("R6 irq on empty start", irq, 1);
    check("R6 busy cleared", busy, 0);

    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0001);
    wr(2'd3, 16'h00B7);
    wr(2'd3, 16'h0003);
    wr(2'd0, 16'h0001);
    wait_idle();
    @(negedge clk);
    ones = $countones(8'hB7) + $countones(8'h03);
    check("R2 single stage is parity", crc_value, 1 ^ (ones & 1));

    seed = 32'h5EED;
    for (int t = 0; t < 25; t++) begin
      int n;
      seed = seed * 1103515245 + 12345;
      wr(2'd1, 16'(seed >> 7));
      wr(2'd0, 16'((seed >> 3) & 16'h0F00));
      seed = seed * 1103515245 + 12345;
      wr(2'd2, 16'(seed >> 9));
      n = 1 + ((seed >> 20) & 7);
      for (int k = 0; k < n; k++) wr(2'd3, 16'(seed >> k));
      wr(2'd0, 16'((m_len << 8) | 1));
      for (int k = 0; k < 4; k++) begin
        repeat (5) @(negedge clk);
        wr(2'd3, 16'(seed >> (k + 11)));
      end
      wait_idle();
      @(negedge clk);
      check("R3 idle after run", busy, 0);
    end

    finish_run();
  end
endmodule